// File: doc/BRIEF.md
# Multiplexed ADC Scan Controller

This block is the device-side acquisition controller of a 16-input analog card. A host reaches it through byte-wide reads and writes in a 16-byte I/O window. Through that window the host picks a scan window of input channels, stores a gain code for each channel, selects which trigger sources may start a conversion, and reads back results and status. The converter itself sits outside the block. The block talks to it through a one-cycle start strobe, a busy input, a done input and a 16-bit result bus.

After every completed conversion the block captures the result and moves the multiplexer pointer to the next channel of the window. It raises a level interrupt request when interrupts are enabled, and it pulses a DMA request strobe when DMA is enabled. The gain code of the channel now being converted is presented to the analog front end at all times. Some offsets act as commands: a write to them has an effect whatever the data. One offset decodes differently for reads and writes.

Top module: `adc_scan_ctrl`

## Requirements
- R1: While reset is applied, and after it, the control byte (offset 0xC) reads 0x00, status (offset 0xD) reads 0x80, the channel pointer and gain code are 0, and irq, dma_req, conv_start and pacer_out_en are low. Asserting reset also drops a pending interrupt.
- R2: Writing offset 0xB stores the first channel from bits 3:0 and the last channel from bits 7:4, and loads the channel pointer with the first channel. The channel pointer drives mux_chan and appears in status bits 3:0.
- R3: Writing offset 0x9 stores bits 2:0 as the gain code of the channel held in bits 3:0 of the most recent 0xB write. gain_code always shows the stored code of the channel on mux_chan.
- R4: Each completed conversion moves the pointer forward by one. When the pointer is on the last channel it goes back to the first. If first is greater than last, the pointer counts up through 15 and on to 0. If first equals last, the channel stays fixed.
- R5: The control byte at 0xC reads back as written. Bit 0 lets a write to 0x8 start a conversion. Bit 1 lets a pacer_tick pulse start one, and bit 2 lets an ext_trig pulse start one. Bit 3 drives pacer_out_en. A trigger whose enable bit is clear has no effect.
- R6: When bit 5 of the control byte is set, a completed conversion sets irq and status bit 6. Any write to 0xA clears them. With bit 5 clear, a conversion leaves irq low.
- R7: Status bit 7 reads 1 when no result has been captured since reset, and while a conversion is pending. It reads 0 once a result has been captured.
- R8: conv_start is a one-cycle pulse in the cycle after an accepted trigger. A trigger that arrives while a conversion is pending, or while conv_busy is high, is ignored.
- R9: A read of 0x8 returns the result low byte and a read of 0x9 returns the high byte. Bits at and above RESULT_BITS read as zero (16 bits on the wide variant, 14 on the narrow one).
- R10: With control bit 4 set, each completed conversion makes dma_req high for exactly one cycle. Status bits 5:4 read 3 when bit 4 is set, and otherwise read control bits 7:6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 4 | Byte offset in the I/O window |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr (reads have no side effects) |
| pacer_tick | input | 1 | Pacer trigger pulse |
| ext_trig | input | 1 | External trigger pulse |
| conv_start | output | 1 | Conversion start strobe to the converter |
| conv_busy | input | 1 | Converter is busy |
| conv_done | input | 1 | Converter result valid, one cycle |
| conv_result | input | 16 | Converter result |
| mux_chan | output | 4 | Channel being converted next |
| gain_code | output | 3 | Gain code for mux_chan |
| pacer_out_en | output | 1 | Pacer output enable |
| irq | output | 1 | Interrupt request (level) |
| dma_req | output | 1 | DMA request strobe |

## Verification
The hardest case to reach is the wrap of the channel pointer when the window crosses channel 15. The first channel is numbered above the last, so the pointer has to count through 15 and on to 0 before it returns to the first channel. The stimulus table programs such windows and runs enough software-triggered conversions to pass the wrap, then compares the pointer value it predicts with the value on the pins. Ignored triggers are also awkward to see, because a rejected trigger changes no output at all. The bench counts conv_start pulses and issues extra triggers while a conversion is pending or while conv_busy is held high. It then checks that the count did not rise and that the status ready bit was left untouched.

// File: rtl/adc_scan_pkg.sv
package adc_scan_pkg;

  localparam int unsigned BYTE_W = 8;
  localparam int unsigned GAIN_W = 3;
  localparam int unsigned RES_W  = 16;

  localparam logic [3:0] OFS_RES_LO = 4'h8;
  localparam logic [3:0] OFS_RES_HI = 4'h9;
  localparam logic [3:0] OFS_IRQCLR = 4'hA;
  localparam logic [3:0] OFS_WINDOW = 4'hB;
  localparam logic [3:0] OFS_CTRL   = 4'hC;
  localparam logic [3:0] OFS_STATUS = 4'hD;

  typedef struct packed {
    logic [1:0] dma_slot;
    logic       irq_en;
    logic       dma_en;
    logic       pacer_oe;
    logic       ext_en;
    logic       pacer_en;
    logic       sw_en;
  } ctrl_t;

  typedef enum logic {ST_IDLE, ST_WAIT} seq_state_e;

endpackage

// File: rtl/adc_gain_bank.sv
module adc_gain_bank #(
  parameter int unsigned CHANNELS = 16,
  parameter int unsigned GAIN_W   = 3,
  localparam int unsigned CHAN_W  = $clog2(CHANNELS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [CHAN_W-1:0] wr_chan,
  input  logic [GAIN_W-1:0] wr_gain,
  input  logic [CHAN_W-1:0] rd_chan,
  output logic [GAIN_W-1:0] rd_gain
);

  logic [GAIN_W-1:0] gain_q [CHANNELS];

  for (genvar ch = 0; ch < CHANNELS; ch++) begin : g_chan
    logic load_en;
    assign load_en = wr_en && (wr_chan == CHAN_W'(ch));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       gain_q[ch] <= '0;
      else if (load_en) gain_q[ch] <= wr_gain;
    end
  end

  assign rd_gain = gain_q[rd_chan];

endmodule

// File: rtl/adc_scan_seq.sv
module adc_scan_seq
  import adc_scan_pkg::*;
#(
  parameter int unsigned CHANNELS = 16,
  localparam int unsigned CHAN_W  = $clog2(CHANNELS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  ctrl_t             ctrl,
  input  logic              sw_trig,
  input  logic              pacer_tick,
  input  logic              ext_trig,
  input  logic              scan_load,
  input  logic [CHAN_W-1:0] scan_first,
  input  logic [CHAN_W-1:0] scan_last,
  input  logic              conv_busy,
  input  logic              conv_done,
  output logic              conv_start,
  output logic              done_now,
  output logic              pending,
  output logic              dma_req,
  output logic [CHAN_W-1:0] cur_chan
);

  seq_state_e        state_q, state_d;
  logic [CHAN_W-1:0] chan_q, chan_d;
  logic              start_q, start_d;
  logic              dma_q, dma_d;
  logic              trig_any;

  function automatic logic [CHAN_W-1:0] step_chan(
    input logic [CHAN_W-1:0] cur,
    input logic [CHAN_W-1:0] first,
    input logic [CHAN_W-1:0] last
  );
    if (cur == last)                          return first;
    else if (cur == CHAN_W'(CHANNELS - 1))    return '0;
    else                                      return cur + 1'b1;
  endfunction

  assign trig_any = (ctrl.sw_en    && sw_trig)
                 || (ctrl.pacer_en && pacer_tick)
                 || (ctrl.ext_en   && ext_trig);

  assign done_now = (state_q == ST_WAIT) && conv_done;

  always_comb begin
    state_d = state_q;
    chan_d  = chan_q;
    start_d = 1'b0;
    dma_d   = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (trig_any && !conv_busy) begin
          state_d = ST_WAIT;
          start_d = 1'b1;
        end
      end
      ST_WAIT: begin
        if (conv_done) begin
          state_d = ST_IDLE;
          chan_d  = step_chan(chan_q, scan_first, scan_last);
          dma_d   = ctrl.dma_en;
        end
      end
      default: state_d = ST_IDLE;
    endcase
    if (scan_load) chan_d = scan_first;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      chan_q  <= '0;
      start_q <= 1'b0;
      dma_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      chan_q  <= chan_d;
      start_q <= start_d;
      dma_q   <= dma_d;
    end
  end

  assign conv_start = start_q;
  assign dma_req    = dma_q;
  assign pending    = (state_q == ST_WAIT);
  assign cur_chan   = chan_q;

  assert_single_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |=> !conv_start);

  assert_busy_blocks_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
    conv_busy |=> !conv_start);

  assert_disabled_no_start_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl.sw_en && !ctrl.pacer_en && !ctrl.ext_en) |=> !conv_start);

  assert_window_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    scan_load |=> (cur_chan == $past(scan_first)));

endmodule

// File: rtl/adc_scan_regs.sv
module adc_scan_regs
  import adc_scan_pkg::*;
#(
  parameter int unsigned CHANNELS    = 16,
  parameter int unsigned RESULT_BITS = 16,
  localparam int unsigned CHAN_W     = $clog2(CHANNELS),
  localparam logic [RES_W-1:0] RES_MASK = RES_W'((32'd1 << RESULT_BITS) - 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [3:0]        bus_addr,
  input  logic              bus_wr,
  input  logic [BYTE_W-1:0] bus_wdata,
  output logic [BYTE_W-1:0] bus_rdata,
  input  logic              done_now,
  input  logic              pending,
  input  logic [RES_W-1:0]  conv_result,
  input  logic [CHAN_W-1:0] cur_chan,
  output ctrl_t             ctrl,
  output logic              sw_trig,
  output logic              scan_load,
  output logic [CHAN_W-1:0] scan_first,
  output logic [CHAN_W-1:0] scan_last,
  output logic              gain_wr,
  output logic [CHAN_W-1:0] gain_sel,
  output logic              irq
);

  ctrl_t             ctrl_q, ctrl_d;
  logic [CHAN_W-1:0] first_q, first_d, last_q, last_d;
  logic [RES_W-1:0]  res_q, res_d;
  logic              have_res_q, have_res_d;
  logic              irq_q, irq_d;
  logic              wr_ctrl, wr_window, wr_clr;
  logic [BYTE_W-1:0] status_byte;

  assign wr_ctrl   = bus_wr && (bus_addr == OFS_CTRL);
  assign wr_window = bus_wr && (bus_addr == OFS_WINDOW);
  assign wr_clr    = bus_wr && (bus_addr == OFS_IRQCLR);
  assign sw_trig   = bus_wr && (bus_addr == OFS_RES_LO);
  assign gain_wr   = bus_wr && (bus_addr == OFS_RES_HI);

  always_comb begin
    ctrl_d     = ctrl_q;
    first_d    = first_q;
    last_d     = last_q;
    res_d      = res_q;
    have_res_d = have_res_q;
    irq_d      = irq_q;
    if (wr_ctrl) ctrl_d = ctrl_t'(bus_wdata);
    if (wr_window) begin
      first_d = bus_wdata[CHAN_W-1:0];
      last_d  = bus_wdata[4 +: CHAN_W];
    end
    if (wr_clr) irq_d = 1'b0;
    if (done_now) begin
      res_d      = conv_result & RES_MASK;
      have_res_d = 1'b1;
      if (ctrl_q.irq_en) irq_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q     <= '0;
      first_q    <= '0;
      last_q     <= '0;
      res_q      <= '0;
      have_res_q <= 1'b0;
      irq_q      <= 1'b0;
    end else begin
      ctrl_q     <= ctrl_d;
      first_q    <= first_d;
      last_q     <= last_d;
      res_q      <= res_d;
      have_res_q <= have_res_d;
      irq_q      <= irq_d;
    end
  end

  always_comb begin
    status_byte        = '0;
    status_byte[3:0]   = 4'(cur_chan);
    status_byte[5:4]   = ctrl_q.dma_en ? 2'b11 : ctrl_q.dma_slot;
    status_byte[6]     = irq_q;
    status_byte[7]     = pending || !have_res_q;
  end

  always_comb begin
    case (bus_addr)
      OFS_RES_LO: bus_rdata = res_q[7:0];
      OFS_RES_HI: bus_rdata = res_q[15:8];
      OFS_WINDOW: bus_rdata = {4'(last_q), 4'(first_q)};
      OFS_CTRL:   bus_rdata = ctrl_q;
      OFS_STATUS: bus_rdata = status_byte;
      default:    bus_rdata = '0;
    endcase
  end

  assign ctrl       = ctrl_q;
  assign scan_load  = wr_window;
  assign scan_first = first_d;
  assign scan_last  = last_q;
  assign gain_sel   = first_q;
  assign irq        = irq_q;

  assert_irq_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_clr && !done_now) |=> !irq);

  assert_irq_needs_enable_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq && !ctrl_q.irq_en) |=> !irq);

endmodule

// File: rtl/adc_scan_ctrl.sv
module adc_scan_ctrl
  import adc_scan_pkg::*;
#(
  parameter int unsigned CHANNELS    = 16,
  parameter int unsigned RESULT_BITS = 16,
  localparam int unsigned CHAN_W     = $clog2(CHANNELS)
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [3:0]  bus_addr,
  input  logic        bus_wr,
  input  logic [7:0]  bus_wdata,
  output logic [7:0]  bus_rdata,
  input  logic        pacer_tick,
  input  logic        ext_trig,
  output logic        conv_start,
  input  logic        conv_busy,
  input  logic        conv_done,
  input  logic [15:0] conv_result,
  output logic [3:0]  mux_chan,
  output logic [2:0]  gain_code,
  output logic        pacer_out_en,
  output logic        irq,
  output logic        dma_req
);

  logic [1:0]        rst_sync_q;
  logic              rst_core_n;
  ctrl_t             ctrl;
  logic              sw_trig, scan_load, gain_wr, done_now, pending;
  logic [CHAN_W-1:0] scan_first, scan_last, gain_sel, cur_chan;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_core_n = rst_sync_q[1];

  adc_scan_regs #(.CHANNELS(CHANNELS), .RESULT_BITS(RESULT_BITS)) u_regs (
    .clk        (clk),
    .rst_n      (rst_core_n),
    .bus_addr   (bus_addr),
    .bus_wr     (bus_wr),
    .bus_wdata  (bus_wdata),
    .bus_rdata  (bus_rdata),
    .done_now   (done_now),
    .pending    (pending),
    .conv_result(conv_result),
    .cur_chan   (cur_chan),
    .ctrl       (ctrl),
    .sw_trig    (sw_trig),
    .scan_load  (scan_load),
    .scan_first (scan_first),
    .scan_last  (scan_last),
    .gain_wr    (gain_wr),
    .gain_sel   (gain_sel),
    .irq        (irq)
  );

  adc_scan_seq #(.CHANNELS(CHANNELS)) u_seq (
    .clk        (clk),
    .rst_n      (rst_core_n),
    .ctrl       (ctrl),
    .sw_trig    (sw_trig),
    .pacer_tick (pacer_tick),
    .ext_trig   (ext_trig),
    .scan_load  (scan_load),
    .scan_first (scan_first),
    .scan_last  (scan_last),
    .conv_busy  (conv_busy),
    .conv_done  (conv_done),
    .conv_start (conv_start),
    .done_now   (done_now),
    .pending    (pending),
    .dma_req    (dma_req),
    .cur_chan   (cur_chan)
  );

  adc_gain_bank #(.CHANNELS(CHANNELS), .GAIN_W(GAIN_W)) u_gain (
    .clk     (clk),
    .rst_n   (rst_core_n),
    .wr_en   (gain_wr),
    .wr_chan (gain_sel),
    .wr_gain (bus_wdata[GAIN_W-1:0]),
    .rd_chan (cur_chan),
    .rd_gain (gain_code)
  );

  assign mux_chan     = 4'(cur_chan);
  assign pacer_out_en = ctrl.pacer_oe;

  assert_dma_after_done_R10: assert property (@(posedge clk) disable iff (!rst_core_n)
    dma_req |-> $past(conv_done));

endmodule

// File: tb/adc_scan_ctrl_bench.sv
module adc_scan_ctrl_bench;

  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic [7:0] window;
    logic [7:0] n_conv;
    logic [3:0] exp_chan;
  } scan_vec_t;

  localparam int NVEC = 6;
  localparam scan_vec_t VECS [NVEC] = '{
    '{8'h30, 8'd2,  4'h2},
    '{8'h30, 8'd4,  4'h0},
    '{8'h55, 8'd3,  4'h5},
    '{8'hFE, 8'd3,  4'hF},
    '{8'h2E, 8'd5,  4'hE},
    '{8'h07, 8'd10, 4'h7}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic [7:0]  bus_wdata = '0;
  logic        pacer_tick = 1'b0, ext_trig = 1'b0;
  logic        conv_busy = 1'b0, conv_done = 1'b0;
  logic [15:0] conv_result = '0;
  logic [7:0]  bus_rdata, bus_rdata_n;
  logic        conv_start, conv_start_n, pacer_out_en, pacer_out_en_n;
  logic        irq, irq_n, dma_req, dma_req_n;
  logic [3:0]  mux_chan, mux_chan_n;
  logic [2:0]  gain_code, gain_code_n;

  int compared = 0;
  int mismatched = 0;
  int n_starts = 0;

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) if (conv_start) n_starts++;

  adc_scan_ctrl u_adc_scan_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pacer_tick(pacer_tick),
    .ext_trig(ext_trig), .conv_start(conv_start), .conv_busy(conv_busy),
    .conv_done(conv_done), .conv_result(conv_result), .mux_chan(mux_chan),
    .gain_code(gain_code), .pacer_out_en(pacer_out_en), .irq(irq),
    .dma_req(dma_req)
  );

  adc_scan_ctrl #(.RESULT_BITS(14)) u_adc_scan_ctrl_narrow (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata_n), .pacer_tick(pacer_tick),
    .ext_trig(ext_trig), .conv_start(conv_start_n), .conv_busy(conv_busy),
    .conv_done(conv_done), .conv_result(conv_result), .mux_chan(mux_chan_n),
    .gain_code(gain_code_n), .pacer_out_en(pacer_out_en_n), .irq(irq_n),
    .dma_req(dma_req_n)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic do_conv(input logic [15:0] r);
    conv_done = 1'b1; conv_result = r;
    @(negedge clk);
    conv_done = 1'b0;
  endtask

  task automatic pulse(input bit use_ext);
    @(negedge clk);
    if (use_ext) ext_trig = 1'b1; else pacer_tick = 1'b1;
    @(negedge clk);
    ext_trig = 1'b0; pacer_tick = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    logic [7:0] v;
    int s0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    rd(4'hC, v); chk("R1 ctrl", v, 8'h00);
    rd(4'hD, v); chk("R1 status", v, 8'h80);
    chk("R1 outputs", {irq, dma_req, conv_start, pacer_out_en, mux_chan, gain_code}, '0);

    // R2/R4 table walk with software trigger
    wr(4'hC, 8'h01);
    for (int i = 0; i < NVEC; i++) begin
      wr(4'hB, VECS[i].window);
      chk("R2 pointer loads first", mux_chan, {28'd0, VECS[i].window[3:0]});
      for (int k = 0; k < int'(VECS[i].n_conv); k++) begin
        wr(4'h8, 8'h00);
        do_conv(16'h0000);
      end
      rd(4'hD, v);
      chk("R4 status next channel", v[3:0], VECS[i].exp_chan);
      chk("R4 mux_chan", mux_chan, VECS[i].exp_chan);
    end
    rd(4'hB, v); chk("R2 window readback", v, 8'h07);

    // R3 per-channel gain
    wr(4'hB, 8'h02); wr(4'h9, 8'h05);
    wr(4'hB, 8'h03); wr(4'h9, 8'h07);
    wr(4'hB, 8'h32);
    chk("R3 gain ch2", gain_code, 3'd5);
    wr(4'h8, 8'h00); do_conv(16'h0);
    chk("R3 gain ch3 after step", gain_code, 3'd7);
    wr(4'hB, 8'h44);
    chk("R3 unwritten channel gain", gain_code, 3'd0);

    // R7/R8/R9 conversion, busy ignore, result readback
    s0 = n_starts;
    wr(4'h8, 8'h00);
    rd(4'hD, v); chk("R7 pending flag", v[7], 1'b1);
    wr(4'h8, 8'h00);
    do_conv(16'hABCD);
    chk("R8 one start despite second trigger", n_starts - s0, 1);
    rd(4'hD, v); chk("R7 result ready", v[7], 1'b0);
    rd(4'h8, v); chk("R9 low byte", v, 8'hCD);
    rd(4'h9, v); chk("R9 high byte", v, 8'hAB);
    bus_addr = 4'h9; #1; chk("R9 narrow high byte masked", bus_rdata_n, 8'h2B);
    conv_busy = 1'b1;
    s0 = n_starts;
    wr(4'h8, 8'h00);
    @(negedge clk);
    conv_busy = 1'b0;
    chk("R8 busy blocks trigger", n_starts - s0, 0);
    rd(4'hD, v); chk("R8 status untouched by ignored trigger", v[7], 1'b0);

    // R5 trigger sources
    wr(4'hC, 8'h02);
    s0 = n_starts;
    pulse(1'b0); do_conv(16'h0);
    chk("R5 pacer trigger", n_starts - s0, 1);
    s0 = n_starts;
    pulse(1'b1); wr(4'h8, 8'h00); @(negedge clk);
    chk("R5 ext and soft ignored when disabled", n_starts - s0, 0);
    wr(4'hC, 8'h04);
    s0 = n_starts;
    pulse(1'b1); do_conv(16'h0);
    chk("R5 ext trigger", n_starts - s0, 1);
    wr(4'hC, 8'h00);
    s0 = n_starts;
    wr(4'h8, 8'h00); pulse(1'b0); pulse(1'b1); @(negedge clk);
    chk("R5 all disabled", n_starts - s0, 0);
    wr(4'hC, 8'h08);
    chk("R5 pacer output enable", pacer_out_en, 1'b1);
    rd(4'hC, v); chk("R5 ctrl readback", v, 8'h08);

    // R6 interrupt
    wr(4'hC, 8'h21);
    wr(4'h8, 8'h00); do_conv(16'h0);
    chk("R6 irq set", irq, 1'b1);
    rd(4'hD, v); chk("R6 status irq bit", v[6], 1'b1);
    wr(4'hA, 8'h5A);
    chk("R6 irq cleared", irq, 1'b0);
    wr(4'hC, 8'h01);
    wr(4'h8, 8'h00); do_conv(16'h0);
    chk("R6 irq stays low when disabled", irq, 1'b0);

    // R10 dma request
    wr(4'hC, 8'h11);
    rd(4'hD, v); chk("R10 source with dma", v[5:4], 2'd3);
    wr(4'h8, 8'h00); do_conv(16'h0);
    chk("R10 dma_req pulse", dma_req, 1'b1);
    @(negedge clk);
    chk("R10 dma_req one cycle", dma_req, 1'b0);
    wr(4'hC, 8'h81);
    rd(4'hD, v); chk("R10 source slot", v[5:4], 2'd2);
    wr(4'h8, 8'h00); do_conv(16'h0);
    chk("R10 no dma_req when disabled", dma_req, 1'b0);

    // R1 reset while an interrupt is pending
    wr(4'hC, 8'h21);
    wr(4'h8, 8'h00); do_conv(16'h0);
    chk("R1 irq before reset", irq, 1'b1);
    rst_n = 1'b0;
    #1;
    chk("R1 irq dropped by reset", irq, 1'b0);
    rd(4'hC, v); chk("R1 ctrl after reset", v, 8'h00);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    rd(4'hD, v); chk("R1 status after reset", v, 8'h80);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule